// File: doc/BRIEF.md
# Power-Loss Memory Shutdown Sequencer

This block is board and chipset logic that takes the memory subsystem into a safe state when mains power fails. A raw power-fail indication is first synchronised to the local clock. It is then qualified by a hold filter, so that a short glitch cannot start a shutdown. Once the indication qualifies, the sequencer raises the refresh-protect signal. It then asks the memory controller to drain its protected write buffers and asks every DIMM to enter self-refresh. After that it announces that refresh protection is complete, which fires the module's save trigger, and finally it requests that the rails and clocks be switched off.

Each handshake wait is bounded by a cycle limit supplied on an input port. If the acknowledge does not arrive in time, the sequencer moves on anyway and sets a sticky timeout flag for that step. Once the sequence has started it cannot be aborted: it runs to the power-off state and stays there until reset. All outputs are decoded from the state register, so none of them depends combinationally on an input.

Top module: `pls_adr_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, every request output is 0 and `tmo_stat_o` is 2'b00.
- R2: `pwr_fail_i` passes through SYNC_STAGES flip-flops. The sequence starts only after the synchronised value has been 1 for HOLD_CYCLES consecutive cycles. A shorter pulse leaves all outputs at 0.
- R3: The first step drives `adr_o`=1 alone for exactly one cycle. `flush_req_o` rises in the next cycle, and `adr_o` stays 1 while it is high.
- R4: While `flush_req_o` is 1, a sampled `flush_done_i`=1 makes the next cycle show `flush_req_o`=0 and `sref_req_o`=1. The two requests are never high together.
- R5: A wait step that has spent `wait_limit_i`+1 cycles without its acknowledge advances anyway and sets its timeout flag: bit 0 for the flush wait, bit 1 for the self-refresh wait. An acknowledge sampled in the same cycle as expiry wins, and no flag is set. Both flags stay set until reset.
- R6: `adr_done_o` rises only in the cycle after the self-refresh wait ends, whether by a sampled `sref_ack_i` or by expiry, so it always follows `sref_req_o`.
- R7: `save_go_o` rises in the same cycle as `adr_done_o` and stays 1.
- R8: `rail_off_o` rises exactly one cycle after `save_go_o` and stays 1.
- R9: Once `adr_o` has risen, dropping `pwr_fail_i` has no effect. Every active output keeps its value until reset.
- R10: An acknowledge presented outside its own wait step is ignored. `flush_done_i` in idle starts nothing, and `sref_ack_i` during the flush wait does not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Raw mains-loss indication, asynchronous |
| flush_done_i | input | 1 | Protected write buffers drained |
| sref_ack_i | input | 1 | All DIMMs are in self-refresh |
| wait_limit_i | input | TMR_W | Cycle limit for each handshake wait |
| adr_o | output | 1 | Refresh-protect signal, held until reset |
| flush_req_o | output | 1 | Request to drain the protected buffers |
| sref_req_o | output | 1 | Self-refresh request to all DIMMs |
| adr_done_o | output | 1 | Refresh protection complete |
| save_go_o | output | 1 | Module save trigger |
| rail_off_o | output | 1 | Rail and clock shutdown request |
| tmo_stat_o | output | 2 | Sticky timeout flags: bit 0 flush, bit 1 self-refresh |

## Verification
The bench builds the block with HOLD_CYCLES=3, SYNC_STAGES=2 and TMR_W=4. A hold of three cycles lets a two-cycle glitch sit just below the start threshold. The 4-bit timer lets the wait limits 0, 5 and 15 cover immediate expiry, an ordinary timeout and the saturating counter ceiling. Each scenario is a few dozen cycles long, so both timeout flags, the case where the acknowledge and expiry arrive together, and a power-fail that drops mid-sequence all come up several times in one short run.

// File: rtl/pls_pkg.sv
package pls_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARM   = 3'd1,
      ST_FLUSH = 3'd2,
      ST_SREF  = 3'd3,
      ST_SAVE  = 3'd4,
      ST_OFF   = 3'd5
   } pls_state_e;

   localparam int TMO_BITS = 2;
   localparam int TMO_FLUSH = 0;
   localparam int TMO_SREF  = 1;
endpackage

// File: rtl/pls_glitch_filter.sv
module pls_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic fire_o
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (HOLD_CYCLES < 1) $error("HOLD_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] shreg;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = shreg[SYNC_STAGES-1];

   generate
      if (HOLD_CYCLES == 1) begin : g_direct
         assign fire_o = synced;
      end else begin : g_count
         localparam int CW = $clog2(HOLD_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run_q <= '0;
            else if (!synced)      run_q <= '0;
            else if (run_q != LAST) run_q <= run_q + 1'b1;
         end

         assign fire_o = synced && (run_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pls_wait_timer.sv
module pls_wait_timer #(
   parameter int TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [TMR_W-1:0] limit_i,
   output logic             expired_o
);
   initial begin
      if (TMR_W < 1) $error("TMR_W must be at least 1");
   end

   localparam logic [TMR_W-1:0] TOP = '1;
   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (clr_i)       cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/pls_fsm.sv
module pls_fsm
   import pls_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire_i,
   input  logic                flush_done_i,
   input  logic                sref_ack_i,
   input  logic                expired_i,
   output logic                clr_o,
   output logic                adr_o,
   output logic                flush_req_o,
   output logic                sref_req_o,
   output logic                adr_done_o,
   output logic                save_go_o,
   output logic                rail_off_o,
   output logic [TMO_BITS-1:0] tmo_stat_o
);
   pls_state_e st_q, st_d;
   logic [TMO_BITS-1:0] tmo_q, tmo_d;

   always_comb begin
      st_d  = st_q;
      tmo_d = tmo_q;
      unique case (st_q)
         ST_IDLE:  if (fire_i) st_d = ST_ARM;
         ST_ARM:   st_d = ST_FLUSH;
         ST_FLUSH: begin
            if (flush_done_i) st_d = ST_SREF;
            else if (expired_i) begin
               st_d = ST_SREF;
               tmo_d[TMO_FLUSH] = 1'b1;
            end
         end
         ST_SREF: begin
            if (sref_ack_i) st_d = ST_SAVE;
            else if (expired_i) begin
               st_d = ST_SAVE;
               tmo_d[TMO_SREF] = 1'b1;
            end
         end
         ST_SAVE:  st_d = ST_OFF;
         ST_OFF:   st_d = ST_OFF;
         default:  st_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         tmo_q <= '0;
      end else begin
         st_q  <= st_d;
         tmo_q <= tmo_d;
      end
   end

   assign clr_o       = (st_d != st_q);
   assign adr_o       = (st_q != ST_IDLE);
   assign flush_req_o = (st_q == ST_FLUSH);
   assign sref_req_o  = (st_q == ST_SREF) || (st_q == ST_SAVE) || (st_q == ST_OFF);
   assign adr_done_o  = (st_q == ST_SAVE) || (st_q == ST_OFF);
   assign save_go_o   = adr_done_o;
   assign rail_off_o  = (st_q == ST_OFF);
   assign tmo_stat_o  = tmo_q;
endmodule

// File: rtl/pls_adr_sequencer.sv
module pls_adr_sequencer #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 4,
   parameter int TMR_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_fail_i,
   input  logic             flush_done_i,
   input  logic             sref_ack_i,
   input  logic [TMR_W-1:0] wait_limit_i,
   output logic             adr_o,
   output logic             flush_req_o,
   output logic             sref_req_o,
   output logic             adr_done_o,
   output logic             save_go_o,
   output logic             rail_off_o,
   output logic [1:0]       tmo_stat_o
);
   logic fire, expired, clr;

   pls_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_CYCLES(HOLD_CYCLES)
   ) u_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pwr_fail_i),
      .fire_o (fire)
   );

   pls_wait_timer #(
      .TMR_W(TMR_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .limit_i   (wait_limit_i),
      .expired_o (expired)
   );

   pls_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .fire_i       (fire),
      .flush_done_i (flush_done_i),
      .sref_ack_i   (sref_ack_i),
      .expired_i    (expired),
      .clr_o        (clr),
      .adr_o        (adr_o),
      .flush_req_o  (flush_req_o),
      .sref_req_o   (sref_req_o),
      .adr_done_o   (adr_done_o),
      .save_go_o    (save_go_o),
      .rail_off_o   (rail_off_o),
      .tmo_stat_o   (tmo_stat_o)
   );
endmodule

// File: rtl/pls_adr_checker.sv
module pls_adr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       adr_o,
   input logic       flush_req_o,
   input logic       sref_req_o,
   input logic       adr_done_o,
   input logic       save_go_o,
   input logic       rail_off_o,
   input logic [1:0] tmo_stat_o
);
   a_r3_flush_after_adr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_req_o) |-> $past(adr_o));

   a_r3_adr_held: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req_o |-> adr_o);

   a_r4_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(flush_req_o && sref_req_o));

   a_r5_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_stat_o != 2'b00) |=> ($countones(tmo_stat_o) >= $countones($past(tmo_stat_o))));

   a_r6_done_after_sref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adr_done_o) |-> $past(sref_req_o));

   a_r7_save_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(save_go_o) |-> $rose(adr_done_o));

   a_r8_rail_after_save: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_off_o) |-> $past(save_go_o));

   a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      adr_o |=> adr_o);

   a_r9_rail_held: assert property (@(posedge clk) disable iff (!rst_n)
      rail_off_o |=> rail_off_o);
endmodule

bind pls_adr_sequencer pls_adr_checker u_pls_adr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .adr_o       (adr_o),
   .flush_req_o (flush_req_o),
   .sref_req_o  (sref_req_o),
   .adr_done_o  (adr_done_o),
   .save_go_o   (save_go_o),
   .rail_off_o  (rail_off_o),
   .tmo_stat_o  (tmo_stat_o)
);

// File: tb/test_pls_adr_sequencer.sv
module test_pls_adr_sequencer;
   localparam int SYNC = 2;
   localparam int HOLD = 3;
   localparam int TW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pf = 1'b0;
   logic          fdone = 1'b0;
   logic          sack = 1'b0;
   logic [TW-1:0] lim = 4'd5;
   logic adr, freq, sreq, done, save, rail;
   logic [1:0] stat;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   pls_adr_sequencer #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD), .TMR_W(TW)) i_pls_adr_sequencer (
      .clk(clk), .rst_n(rst_n), .pwr_fail_i(pf), .flush_done_i(fdone),
      .sref_ack_i(sack), .wait_limit_i(lim), .adr_o(adr), .flush_req_o(freq),
      .sref_req_o(sreq), .adr_done_o(done), .save_go_o(save), .rail_off_o(rail),
      .tmo_stat_o(stat));

   // Behavioural reference: step 0 idle, 1 arm, 2 flush, 3 self-refresh, 4 save, 5 off
   bit syncq[$];
   int m_run, m_step, m_wait;
   bit [1:0] m_tmo;

   task automatic model_reset();
      syncq = {};
      for (int i = 0; i < SYNC; i++) syncq.push_front(1'b0);
      m_run = 0; m_step = 0; m_wait = 0; m_tmo = 2'b00;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit s_now, started, expired;
         int nxt;
         s_now   = syncq[$];
         started = s_now && (m_run + 1 >= HOLD);
         expired = (m_wait >= int'(lim));
         nxt = m_step;
         case (m_step)
            0: if (started) nxt = 1;
            1: nxt = 2;
            2: if (fdone) nxt = 3; else if (expired) begin nxt = 3; m_tmo[0] = 1'b1; end
            3: if (sack) nxt = 4; else if (expired) begin nxt = 4; m_tmo[1] = 1'b1; end
            default: nxt = 5;
         endcase
         if (nxt != m_step) m_wait = 0;
         else if (m_wait < (1 << TW) - 1) m_wait++;
         m_step = nxt;
         m_run = s_now ? ((m_run < 1000) ? m_run + 1 : m_run) : 0;
         syncq.push_front(pf);
         void'(syncq.pop_back());
      end
   end

   task automatic cmp(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
      end
   endtask

   // Per-clock comparison against the reference, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         cmp("R3 adr_o",      int'(adr),  int'(m_step != 0));
         cmp("R4 flush_req",  int'(freq), int'(m_step == 2));
         cmp("R4 sref_req",   int'(sreq), int'(m_step >= 3));
         cmp("R6 adr_done",   int'(done), int'(m_step >= 4));
         cmp("R7 save_go",    int'(save), int'(m_step >= 4));
         cmp("R8 rail_off",   int'(rail), int'(m_step == 5));
         cmp("R5 tmo_stat",   int'(stat), int'(m_tmo));
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pf = 1'b0; fdone = 1'b0; sack = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic wait_for_rail();
      for (int i = 0; i < 200 && !rail; i++) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      tick(3);
      cmp("R1 outputs in reset", int'({adr, freq, sreq, done, save, rail}), 0);
      cmp("R1 status in reset", int'(stat), 0);
      rst_n = 1'b1;
      tick(1);
      cmp("R1 outputs after release", int'({adr, freq, sreq, done, save, rail}), 0);

      // R2: glitch one cycle shorter than the hold is ignored; R10: flush_done in idle ignored
      fdone = 1'b1;
      pf = 1'b1; tick(HOLD - 1); pf = 1'b0;
      tick(8);
      cmp("R2 short glitch no start", int'(adr), 0);
      cmp("R10 flush_done in idle", int'({adr, freq, sreq}), 0);
      fdone = 1'b0;

      // Normal run with handshakes; R3 ordering, R4, R7, R8, R9
      lim = 4'd15;
      pf = 1'b1;
      for (int i = 0; i < 40 && !adr; i++) @(negedge clk);
      cmp("R3 adr alone first", int'({adr, freq}), 2);
      tick(1);
      cmp("R3 flush after adr", int'({adr, freq}), 3);
      tick(2); fdone = 1'b1; tick(1); fdone = 1'b0;
      cmp("R4 sref after flush_done", int'({freq, sreq}), 1);
      pf = 1'b0;
      tick(3); sack = 1'b1; tick(1);
      cmp("R7 save with done", int'({done, save, rail}), 6);
      tick(1);
      cmp("R8 rail one cycle after save", int'(rail), 1);
      tick(10);
      cmp("R9 held after pf drop", int'({adr, rail}), 3);
      cmp("R5 no timeouts", int'(stat), 0);

      // R5: both waits expire
      do_reset();
      lim = 4'd5; pf = 1'b1;
      wait_for_rail();
      cmp("R5 both flags", int'(stat), 3);
      tick(5);
      cmp("R5 flags sticky", int'(stat), 3);

      // R10: sref_ack during flush wait ignored; flush times out, sref acked at once
      do_reset();
      lim = 4'd15; sack = 1'b1; pf = 1'b1;
      for (int i = 0; i < 40 && !freq; i++) @(negedge clk);
      tick(4);
      cmp("R10 sref_ack during flush", int'({freq, sreq}), 2);
      wait_for_rail();
      cmp("R10 flush flag only", int'(stat), 1);

      // R5: zero limit expires on the first wait cycle; R9 pf dropped mid-flush
      do_reset();
      lim = 4'd0; pf = 1'b1;
      for (int i = 0; i < 40 && !freq; i++) @(negedge clk);
      pf = 1'b0;
      tick(1);
      cmp("R5 zero limit advances", int'(sreq), 1);
      tick(4);
      cmp("R9 pf drop mid-sequence", int'(rail), 1);

      // R5: ack coinciding with expiry wins
      do_reset();
      lim = 4'd2; pf = 1'b1;
      for (int i = 0; i < 40 && !freq; i++) @(negedge clk);
      tick(2); fdone = 1'b1; tick(1); fdone = 1'b0;
      cmp("R5 ack beats expiry", int'(stat[0]), 0);
      wait_for_rail();
      tick(2);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule